// File: doc/BRIEF.md
# Tick-Driven 16-bit Interval Timer

The block is a 16-bit counting peripheral on a simple word-wide register bus. It counts single-cycle enable pulses from one of several tick sources and raises an interrupt request. Each tick comes from a slower clock domain and is already synchronised to `clk`. A two-bit mode field picks how the counter moves. It can hold still. It can count from zero up to a programmed period and restart. It can run freely over the whole 16-bit range. It can rise to the period and fall back to zero as a triangle.

Two event flags record where the count has been. The match flag sets when a tick brings the counter onto the period value. The zero flag sets when a tick brings a non-zero counter to zero. Each flag has its own enable, and the interrupt line is the OR of the two enabled flags. Software clears a flag by writing 0 to its bit. Software can also load the counter directly, or clear it with a self-clearing bit in the control register.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq` is low.
- R2: Registers sit at these addresses. The control register is at 0x0160: bit 0 is the zero flag, bit 1 the zero-flag enable, bit 2 a clear strobe that always reads 0, bits 5:4 the mode, and bits 9:8 the tick source. The match control register is at 0x0162: bit 0 is the match flag and bit 4 the match enable. The counter is at 0x0170 and the period is at 0x0172. `bus_rdata` shows the register at `bus_addr` one cycle after the address is presented.
- R3: The counter moves only on a cycle where the source chosen by control bits 9:8 pulses. Pulses on other sources have no effect, and mode 0 holds the counter.
- R4: In mode 1 (up), a tick adds one while the counter is below the period. A tick with the counter at or above the period sets it to 0.
- R5: In mode 2 (continuous), a tick adds one and 0xFFFF wraps to 0x0000.
- R6: In mode 3 (up/down), the counter rises to the period, then falls one per tick to 0, then rises again: 0,1,..,P,P-1,..,0,1.
- R7: A tick that brings the counter onto the period value sets the match flag. A tick that brings a non-zero counter to 0 sets the zero flag.
- R8: `irq` is high when (match flag and match enable) or (zero flag and zero enable). Writing 0 to a flag bit clears that flag.
- R9: A write to 0x0170 loads the counter, and this takes priority over a tick in the same cycle. A control write with bit 2 set clears the counter and restarts up/down counting upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| src_tick | input | 4 | One enable pulse line per tick source |
| irq | output | 1 | Interrupt request |

## Verification
The same period of 3 is run through up, up/down and continuous mode, and every step is read back. This shows whether each mode restarts, turns around or wraps at the right value. Flag enables are switched between the runs, so the match event and the zero event each raise `irq` on their own. This tells apart a wrong event from a wrong enable. Ticks are also sent on sources that are not selected, and sent in stop mode. A counter loaded above the period, a load that coincides with a tick, and a load just below 0xFFFF cover the boundary paths.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } tmr_mode_e;

  localparam int CTL_ZF_BIT   = 0;
  localparam int CTL_ZIE_BIT  = 1;
  localparam int CTL_CLR_BIT  = 2;
  localparam int CTL_MODE_LSB = 4;
  localparam int CTL_SRC_LSB  = 8;
  localparam int MC_FLAG_BIT  = 0;
  localparam int MC_IE_BIT    = 4;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int N_SRC = 4,
  parameter int SEL_W = 2
) (
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = src[i] && (sel == SEL_W'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  tmr_mode_e    mode,
  input  logic [W-1:0] period,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         hit_cmp,
  output logic         hit_zero
);
  logic [W-1:0] nxt;
  logic         down_q, down_nxt;
  logic         moved;

  always_comb begin
    nxt      = cnt;
    down_nxt = down_q;
    moved    = 1'b0;
    if (load) begin
      nxt      = load_val;
      down_nxt = 1'b0;
    end else if (clr) begin
      nxt      = '0;
      down_nxt = 1'b0;
    end else if (tick) begin
      unique case (mode)
        MODE_UP: begin
          moved    = 1'b1;
          down_nxt = 1'b0;
          nxt      = (cnt >= period) ? '0 : cnt + W'(1);
        end
        MODE_CONT: begin
          moved = 1'b1;
          nxt   = cnt + W'(1);
        end
        MODE_UPDN: begin
          moved = 1'b1;
          if (period == '0) begin
            nxt      = '0;
            down_nxt = 1'b0;
          end else if (!down_q) begin
            if (cnt >= period) begin
              nxt      = cnt - W'(1);
              down_nxt = 1'b1;
            end else begin
              nxt = cnt + W'(1);
            end
          end else if (cnt == '0) begin
            nxt      = W'(1);
            down_nxt = 1'b0;
          end else begin
            nxt = cnt - W'(1);
            if (cnt == W'(1)) down_nxt = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign hit_cmp  = moved && (nxt == period) && (nxt != cnt);
  assign hit_zero = moved && (nxt == '0) && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else begin
      cnt    <= nxt;
      down_q <= down_nxt;
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          AW       = 16,
  parameter int          SEL_W    = 2,
  parameter logic [15:0] A_CTL    = 16'h0160,
  parameter logic [15:0] A_MCTL   = 16'h0162,
  parameter logic [15:0] A_CNT    = 16'h0170,
  parameter logic [15:0] A_PERIOD = 16'h0172
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     cnt,
  input  logic             hit_cmp,
  input  logic             hit_zero,
  output tmr_mode_e        mode,
  output logic [SEL_W-1:0] sel,
  output logic [W-1:0]     period,
  output logic             load,
  output logic             clr,
  output logic             irq,
  output logic [W-1:0]     rdata
);
  logic wr_ctl, wr_mctl, wr_per;
  logic zf_q, zie_q, mf_q, mie_q;
  logic [W-1:0] rd_mux;

  assign wr_ctl  = wr && (addr == AW'(A_CTL));
  assign wr_mctl = wr && (addr == AW'(A_MCTL));
  assign wr_per  = wr && (addr == AW'(A_PERIOD));
  assign load    = wr && (addr == AW'(A_CNT));
  assign clr     = wr_ctl && wdata[CTL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_STOP;
      sel    <= '0;
      period <= '0;
      zf_q   <= 1'b0;
      zie_q  <= 1'b0;
      mf_q   <= 1'b0;
      mie_q  <= 1'b0;
    end else begin
      if (wr_ctl) begin
        mode  <= tmr_mode_e'(wdata[CTL_MODE_LSB +: 2]);
        sel   <= wdata[CTL_SRC_LSB +: SEL_W];
        zie_q <= wdata[CTL_ZIE_BIT];
      end
      if (wr_mctl) mie_q <= wdata[MC_IE_BIT];
      if (wr_per)  period <= wdata;
      if (hit_zero)    zf_q <= 1'b1;
      else if (wr_ctl) zf_q <= wdata[CTL_ZF_BIT];
      if (hit_cmp)      mf_q <= 1'b1;
      else if (wr_mctl) mf_q <= wdata[MC_FLAG_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(A_CTL)) begin
      rd_mux[CTL_ZF_BIT]              = zf_q;
      rd_mux[CTL_ZIE_BIT]             = zie_q;
      rd_mux[CTL_MODE_LSB +: 2]       = mode;
      rd_mux[CTL_SRC_LSB +: SEL_W]    = sel;
    end else if (addr == AW'(A_MCTL)) begin
      rd_mux[MC_FLAG_BIT] = mf_q;
      rd_mux[MC_IE_BIT]   = mie_q;
    end else if (addr == AW'(A_CNT)) begin
      rd_mux = cnt;
    end else if (addr == AW'(A_PERIOD)) begin
      rd_mux = period;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign irq = (mf_q && mie_q) || (zf_q && zie_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          AW       = 16,
  parameter int          N_SRC    = 4,
  parameter logic [15:0] A_CTL    = 16'h0160,
  parameter logic [15:0] A_MCTL   = 16'h0162,
  parameter logic [15:0] A_CNT    = 16'h0170,
  parameter logic [15:0] A_PERIOD = 16'h0172
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [N_SRC-1:0] src_tick,
  output logic             irq
);
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  tmr_mode_e        mode_w;
  logic [SEL_W-1:0] sel_w;
  logic [W-1:0]     period_w, cnt_w;
  logic             sel_tick, cnt_load, cnt_clr, hit_cmp, hit_zero;

  tmr_tick_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
    .src  (src_tick),
    .sel  (sel_w),
    .tick (sel_tick)
  );

  tmr_core #(.W(W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (sel_tick),
    .mode     (mode_w),
    .period   (period_w),
    .load     (cnt_load),
    .load_val (bus_wdata),
    .clr      (cnt_clr),
    .cnt      (cnt_w),
    .hit_cmp  (hit_cmp),
    .hit_zero (hit_zero)
  );

  tmr_regs #(
    .W(W), .AW(AW), .SEL_W(SEL_W),
    .A_CTL(A_CTL), .A_MCTL(A_MCTL), .A_CNT(A_CNT), .A_PERIOD(A_PERIOD)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .cnt      (cnt_w),
    .hit_cmp  (hit_cmp),
    .hit_zero (hit_zero),
    .mode     (mode_w),
    .sel      (sel_w),
    .period   (period_w),
    .load     (cnt_load),
    .clr      (cnt_clr),
    .irq      (irq),
    .rdata    (bus_rdata)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         load,
  input logic         clr,
  input logic [1:0]   mode,
  input logic [W-1:0] cnt,
  input logic [W-1:0] period,
  input logic [W-1:0] wdata,
  input logic         hit_zero,
  input logic         irq
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && cnt == '0));

  a_r3_no_tick_holds: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load && !clr) |=> $stable(cnt));

  a_r3_stop_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && !load && !clr) |=> $stable(cnt));

  a_r4_up_restart: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && tick && !load && !clr && cnt >= period) |=> cnt == '0);

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && tick && !load && !clr && cnt == {W{1'b1}}) |=> cnt == '0);

  a_r6_turn_down: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && tick && !load && !clr && period != '0 && cnt == period)
      |=> cnt == $past(period) - W'(1));

  a_r7_zero_event: assert property (@(posedge clk) disable iff (rst)
    hit_zero |=> cnt == '0);

  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(wdata));
endmodule

bind tick_timer tick_timer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (sel_tick),
  .load     (cnt_load),
  .clr      (cnt_clr),
  .mode     (mode_w),
  .cnt      (cnt_w),
  .period   (period_w),
  .wdata    (bus_wdata),
  .hit_zero (hit_zero),
  .irq      (irq)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_CTL = 16'h0160, A_MCTL = 16'h0162,
                          A_CNT = 16'h0170, A_PER = 16'h0172;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  src_tick = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick), .irq(irq)
  );

  // wr, addr, data, tick mask, expected counter, expected irq
  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] data;
    logic [3:0]  tk;
    logic [15:0] ecnt;
    logic        eirq;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0172, 16'h0003, 4'h0, 16'h0000, 1'b0}, // R2 period=3
    '{1'b1, 16'h0162, 16'h0010, 4'h0, 16'h0000, 1'b0}, // match enable
    '{1'b1, 16'h0160, 16'h0010, 4'h0, 16'h0000, 1'b0}, // up mode
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0001, 1'b0}, // R4
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0002, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0003, 1'b1}, // R7 match
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0000, 1'b1}, // R4 restart
    '{1'b1, 16'h0162, 16'h0010, 4'h0, 16'h0000, 1'b0}, // R8 clear flag
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0001, 1'b0},
    '{1'b1, 16'h0160, 16'h0030, 4'h0, 16'h0001, 1'b0}, // up/down
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0002, 1'b0}, // R6
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0003, 1'b1},
    '{1'b1, 16'h0162, 16'h0010, 4'h0, 16'h0003, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0002, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0001, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0000, 1'b0}, // zero flag, no enable
    '{1'b1, 16'h0160, 16'h0032, 4'h0, 16'h0000, 1'b0}, // zero enable, flag cleared
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0001, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0002, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0003, 1'b1},
    '{1'b1, 16'h0162, 16'h0000, 4'h0, 16'h0003, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0002, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0001, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0000, 1'b1}, // R7 zero event
    '{1'b1, 16'h0160, 16'h0022, 4'h0, 16'h0000, 1'b0}, // continuous
    '{1'b1, 16'h0170, 16'hFFFE, 4'h0, 16'hFFFE, 1'b0}, // R9 load
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'hFFFF, 1'b0}, // R5
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0000, 1'b1}, // R5 wrap
    '{1'b1, 16'h0160, 16'h0000, 4'h0, 16'h0000, 1'b0}, // stop
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0000, 1'b0}, // R3 stop holds
    '{1'b1, 16'h0160, 16'h0120, 4'h0, 16'h0000, 1'b0}, // source 1
    '{1'b0, 16'h0000, 16'h0000, 4'h1, 16'h0000, 1'b0}, // R3 other source
    '{1'b0, 16'h0000, 16'h0000, 4'h2, 16'h0001, 1'b0},
    '{1'b0, 16'h0000, 16'h0000, 4'h8, 16'h0001, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [15:0] a, input logic [15:0] d,
                      input logic [3:0] tk);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; src_tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; src_tick = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].tk);
      rd(A_CNT, v);
      check($sformatf("R3/R4/R5/R6 vec%0d counter", i), v, VEC[i].ecnt);
      check($sformatf("R7/R8 vec%0d irq", i), {15'd0, irq}, {15'd0, VEC[i].eirq});
    end

    // R4: counter above period restarts at 0
    step(1'b1, A_CTL, 16'h0010, 4'h0);
    step(1'b1, A_PER, 16'h0003, 4'h0);
    step(1'b1, A_CNT, 16'h0005, 4'h0);
    step(1'b0, 16'h0000, 16'h0000, 4'h1);
    rd(A_CNT, v);
    check("R4 above period", v, 16'h0000);

    // R9: load beats a same-cycle tick
    step(1'b1, A_CNT, 16'h0040, 4'h1);
    rd(A_CNT, v);
    check("R9 load priority", v, 16'h0040);

    // R9: clear strobe; R2 strobe reads as 0
    step(1'b1, A_CTL, 16'h0014, 4'h0);
    rd(A_CNT, v);
    check("R9 clear strobe", v, 16'h0000);
    rd(A_CTL, v);
    check("R2 control readback", v, 16'h0010);
    rd(A_PER, v);
    check("R2 period readback", v, 16'h0003);
    step(1'b1, A_MCTL, 16'h0010, 4'h0);
    rd(A_MCTL, v);
    check("R2 match control readback", v, 16'h0010);

    // R1: reset state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rd(A_CTL, v);  check("R1 control", v, 16'h0000);
    rd(A_MCTL, v); check("R1 match control", v, 16'h0000);
    rd(A_CNT, v);  check("R1 counter", v, 16'h0000);
    rd(A_PER, v);  check("R1 period", v, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule